// File: doc/BRIEF.md
# Video Output Round and Format Stage

This block is the last stage of a video output pipeline. It takes three wide intermediate channels (luma or green, blue-difference or blue, red-difference or red) and turns each into a 10-bit output word. Each channel is clipped to its legal range and rounded to either full 10-bit resolution or to 8-bit resolution held inside the 10-bit word. The two colour-difference ports are then coded as two's complement or offset binary. The three ports are driven through an active-low output enable.

Inputs are signed fixed-point numbers with `FRAC_W` fractional bits below the output LSB. A mode input says whether the upstream matrix produced RGB or whether the channels still carry luma and colour difference. A select input adds a fixed `EQ_DLY`-cycle delay to the path. This lets a stream that skipped an upstream correction filter line up with one that went through it.

Top module: `vof_top`

## Requirements
- R1: With `rnd10` high, each channel adds half an output LSB (2^(FRAC_W-1) in input units) and then drops the `FRAC_W` fractional bits, giving round-half-up at 10-bit resolution.
- R2: With `rnd10` low, each channel adds 2 output LSBs (weight of code bit 1), drops the fractional bits and forces code bits 1 and 0 to zero.
- R3: Before rounding, an unsigned channel is clipped to [0, 1023 + (2^FRAC_W-1)/2^FRAC_W]. A signed channel is clipped to [-512, 511 + (2^FRAC_W-1)/2^FRAC_W] (in output LSBs).
- R4: A rounding carry past full scale saturates. The limit is 1023 (unsigned) or 511 (signed) at 10-bit resolution, and 1020 or 508 at 8-bit resolution.
- R5: With `rgb_mode` low and `convert` high, ports B and C carry the signed colour-difference code as 10-bit two's complement.
- R6: With `rgb_mode` low and `convert` low, ports B and C carry offset binary: the two's complement code with bit 9 inverted.
- R7: With `rgb_mode` high, ports B and C are clipped as unsigned 0..1023 and `convert` has no effect.
- R8: Port A is always clipped and coded as unsigned 0..1023, whatever the mode inputs.
- R9: With `oe_n` high, all three ports are high impedance. With `oe_n` low, they drive the formatted codes. The enable acts without a clock.
- R10: With `eq_dly_en` low, a sample presented before clock edge k appears after edge k+1 (2 cycles). With `eq_dly_en` high, it appears after edge k+1+EQ_DLY.
- R11: While reset is asserted and until the first new sample passes through, all three driven ports read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| oe_n | input | 1 | Active-low output enable for ports A, B, C |
| rgb_mode | input | 1 | High: channels are R/G/B (all unsigned); low: luma and colour difference |
| convert | input | 1 | Colour-difference coding: high two's complement, low offset binary |
| rnd10 | input | 1 | High: 10-bit rounding; low: 8-bit rounding in the 10-bit word |
| eq_dly_en | input | 1 | High: insert EQ_DLY extra cycles of latency |
| y_g_in | input | IN_W | Luma / green channel, signed fixed point |
| cb_b_in | input | IN_W | Blue-difference / blue channel, signed fixed point |
| cr_r_in | input | IN_W | Red-difference / red channel, signed fixed point |
| port_a | output | 10 | Luma / green code |
| port_b | output | 10 | Blue-difference / blue code |
| port_c | output | 10 | Red-difference / red code |

## Verification
The bench keeps the defaults: IN_W = 14, FRAC_W = 2 and EQ_DLY = 2. Two fractional bits make exact half-LSB inputs reachable, so the round-half-up tie for both signs can be tested. Fourteen input bits reach well past both clip limits, so both saturation branches can be driven. With EQ_DLY = 2, the 2-cycle and 4-cycle latencies can be told apart with a single change of input.

// File: rtl/vof_pkg.sv
package vof_pkg;
  localparam int CODE_W = 10;
  localparam int NCH    = 3;

  typedef enum logic [1:0] {
    CH_LUMA = 2'd0,
    CH_BLUE = 2'd1,
    CH_RED  = 2'd2
  } chan_e;

  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/vof_chan.sv
module vof_chan
  import vof_pkg::*;
#(
  parameter int IN_W   = 14,
  parameter int FRAC_W = 2
) (
  input  logic signed [IN_W-1:0] din,
  input  logic                   is_signed,
  input  logic                   rnd10,
  input  logic                   twos,
  output code_t                  code
);
  localparam int CW      = IN_W + 2;
  localparam int ONE     = 1 << FRAC_W;
  localparam int U_HI    = 1024 * ONE - 1;
  localparam int S_HI    = 512 * ONE - 1;
  localparam int S_LO    = -512 * ONE;
  localparam int HALF10  = ONE / 2;
  localparam int HALF8   = 2 * ONE;

  logic signed [CW-1:0] x_ext;
  logic signed [CW-1:0] lo_lim;
  logic signed [CW-1:0] hi_lim;
  logic signed [CW-1:0] clip_v;
  logic signed [CW-1:0] sum_v;
  logic signed [CW-1:0] shr_v;
  logic signed [CW-1:0] cut_v;
  logic signed [CW-1:0] cap_v;
  logic signed [CW-1:0] sat_v;

  assign x_ext  = CW'(din);
  assign lo_lim = is_signed ? CW'(S_LO) : '0;
  assign hi_lim = is_signed ? CW'(S_HI) : CW'(U_HI);

  // clip at full precision
  always_comb begin
    if (x_ext < lo_lim)      clip_v = lo_lim;
    else if (x_ext > hi_lim) clip_v = hi_lim;
    else                     clip_v = x_ext;
  end

  // round at the selected resolution
  assign sum_v = clip_v + (rnd10 ? CW'(HALF10) : CW'(HALF8));
  assign shr_v = sum_v >>> FRAC_W;
  assign cut_v = rnd10 ? shr_v : (shr_v & ~CW'(3));

  // saturate a carry past full scale
  always_comb begin
    if (is_signed) cap_v = rnd10 ? CW'(511)  : CW'(508);
    else           cap_v = rnd10 ? CW'(1023) : CW'(1020);
    sat_v = (cut_v > cap_v) ? cap_v : cut_v;
  end

  // coding of the output word
  always_comb begin
    code = sat_v[CODE_W-1:0];
    if (is_signed && !twos) code[CODE_W-1] = ~sat_v[CODE_W-1];
  end
endmodule

// File: rtl/vof_dly.sv
module vof_dly #(
  parameter int W     = 30,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         srst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg_q [DEPTH];
  logic [W-1:0] stg_d [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_head
        assign stg_d[i] = din;
      end else begin : g_body
        assign stg_d[i] = stg_q[i-1];
      end

      always_ff @(posedge clk or negedge srst_n) begin
        if (!srst_n) stg_q[i] <= '0;
        else         stg_q[i] <= stg_d[i];
      end
    end
  endgenerate

  assign dout = stg_q[DEPTH-1];
endmodule

// File: rtl/vof_top.sv
module vof_top
  import vof_pkg::*;
#(
  parameter int IN_W   = 14,
  parameter int FRAC_W = 2,
  parameter int EQ_DLY = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            oe_n,
  input  logic            rgb_mode,
  input  logic            convert,
  input  logic            rnd10,
  input  logic            eq_dly_en,
  input  logic [IN_W-1:0] y_g_in,
  input  logic [IN_W-1:0] cb_b_in,
  input  logic [IN_W-1:0] cr_r_in,
  output logic [9:0]      port_a,
  output logic [9:0]      port_b,
  output logic [9:0]      port_c
);
  localparam int BUS_W = NCH * CODE_W;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  // per-channel clip, round and coding
  logic signed [IN_W-1:0] chan_in [NCH];
  logic [BUS_W-1:0]       code_d;
  logic [BUS_W-1:0]       code_q;

  assign chan_in[CH_LUMA] = y_g_in;
  assign chan_in[CH_BLUE] = cb_b_in;
  assign chan_in[CH_RED]  = cr_r_in;

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
      logic ch_signed;
      if (ch == CH_LUMA) begin : g_luma
        assign ch_signed = 1'b0;
      end else begin : g_diff
        assign ch_signed = ~rgb_mode;
      end

      vof_chan #(
        .IN_W  (IN_W),
        .FRAC_W(FRAC_W)
      ) u_chan (
        .din      (chan_in[ch]),
        .is_signed(ch_signed),
        .rnd10    (rnd10),
        .twos     (convert),
        .code     (code_d[ch*CODE_W +: CODE_W])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) code_q <= '0;
    else         code_q <= code_d;
  end

  // latency equalisation
  logic [BUS_W-1:0] dly_tail;
  logic [BUS_W-1:0] out_d;
  logic [BUS_W-1:0] out_q;

  vof_dly #(
    .W    (BUS_W),
    .DEPTH(EQ_DLY)
  ) u_dly (
    .clk   (clk),
    .srst_n(srst_n),
    .din   (code_q),
    .dout  (dly_tail)
  );

  always_comb begin
    out_d = eq_dly_en ? dly_tail : code_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) out_q <= '0;
    else         out_q <= out_d;
  end

  // output enable
  assign port_a = oe_n ? 10'bz : out_q[CH_LUMA*CODE_W +: CODE_W];
  assign port_b = oe_n ? 10'bz : out_q[CH_BLUE*CODE_W +: CODE_W];
  assign port_c = oe_n ? 10'bz : out_q[CH_RED*CODE_W +: CODE_W];
endmodule

// File: rtl/vof_chk.sv
module vof_chk #(
  parameter int IN_W = 14
) (
  input logic            clk,
  input logic            srst_n,
  input logic            rgb_mode,
  input logic            convert,
  input logic            rnd10,
  input logic            eq_dly_en,
  input logic [IN_W-1:0] y_g_in,
  input logic [IN_W-1:0] cb_b_in,
  input logic [29:0]     code_q,
  input logic [29:0]     out_q
);
  // R2: 8-bit rounding leaves bits 1:0 clear on all three channels
  p_low_clear_r2: assert property (@(posedge clk) disable iff (!srst_n)
    !rnd10 |=> (code_q[1:0] == 2'b00 && code_q[11:10] == 2'b00 && code_q[21:20] == 2'b00));

  // R5: zero colour difference in two's complement is code 0
  p_twos_zero_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (!rgb_mode && convert && cb_b_in == '0) |=> code_q[19:10] == 10'h000);

  // R6: zero colour difference in offset binary is mid code
  p_offset_mid_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (!rgb_mode && !convert && cb_b_in == '0) |=> code_q[19:10] == 10'h200);

  // R7: negative blue in RGB mode clips to zero
  p_rgb_floor_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (rgb_mode && cb_b_in[IN_W-1]) |=> code_q[19:10] == 10'h000);

  // R8: negative luma always clips to zero
  p_luma_floor_r8: assert property (@(posedge clk) disable iff (!srst_n)
    y_g_in[IN_W-1] |=> code_q[9:0] == 10'h000);

  // R10: without the extra delay the output follows the code register by one cycle
  p_lat_short_r10: assert property (@(posedge clk) disable iff (!srst_n)
    !eq_dly_en |=> out_q == $past(code_q));
endmodule

bind vof_top vof_chk #(.IN_W(IN_W)) u_vof_chk (
  .clk      (clk),
  .srst_n   (srst_n),
  .rgb_mode (rgb_mode),
  .convert  (convert),
  .rnd10    (rnd10),
  .eq_dly_en(eq_dly_en),
  .y_g_in   (y_g_in),
  .cb_b_in  (cb_b_in),
  .code_q   (code_q),
  .out_q    (out_q)
);

// File: tb/test_vof_top.sv
`timescale 1ns/1ps
module test_vof_top;
  localparam int IN_W = 14;

  typedef struct packed {
    logic                   rgb;
    logic                   conv;
    logic                   r10;
    logic signed [IN_W-1:0] a;
    logic signed [IN_W-1:0] b;
    logic signed [IN_W-1:0] c;
    logic [9:0]             ea;
    logic [9:0]             eb;
    logic [9:0]             ec;
  } vec_t;

  // inputs in quarter LSBs (FRAC_W = 2)
  localparam vec_t VEC [8] = '{
    '{1'b0, 1'b1, 1'b1,  14'sd1601,  -14'sd402,  14'sd202, 10'd400,  10'd924, 10'd51 },  // R1 R5
    '{1'b0, 1'b0, 1'b1,  14'sd1601,  -14'sd402,  14'sd202, 10'd400,  10'd412, 10'd563},  // R6
    '{1'b1, 1'b1, 1'b1,  -14'sd40,   14'sd5000,  14'sd2000, 10'd0,   10'd1023, 10'd500}, // R3 R4 R7
    '{1'b0, 1'b1, 1'b0,  14'sd1604,  14'sd4095,  -14'sd3000, 10'd400, 10'd508, 10'd512}, // R2 R4
    '{1'b0, 1'b0, 1'b0,  14'sd4094,  14'sd6,     14'sd8,    10'd1020, 10'd512, 10'd516}, // R2 R4 R6
    '{1'b1, 1'b0, 1'b0,  14'sd0,     14'sd23,    -14'sd1,   10'd0,    10'd4,   10'd0  }, // R2 R7
    '{1'b0, 1'b1, 1'b1,  14'sd8191,  -14'sd8192, 14'sd2046, 10'd1023, 10'd512, 10'd511}, // R3 R4 R8
    '{1'b0, 1'b1, 1'b1,  14'sd6,     -14'sd6,    14'sd5,    10'd2,    10'd1023, 10'd1 }  // R1
  };

  logic            clk = 1'b0;
  logic            rst_n;
  logic            oe_n;
  logic            rgb_mode;
  logic            convert;
  logic            rnd10;
  logic            eq_dly_en;
  logic [IN_W-1:0] y_g_in;
  logic [IN_W-1:0] cb_b_in;
  logic [IN_W-1:0] cr_r_in;
  wire  [9:0]      port_a;
  wire  [9:0]      port_b;
  wire  [9:0]      port_c;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  vof_top #(.IN_W(IN_W), .FRAC_W(2), .EQ_DLY(2)) i_vof_top (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .rgb_mode(rgb_mode),
    .convert(convert), .rnd10(rnd10), .eq_dly_en(eq_dly_en),
    .y_g_in(y_g_in), .cb_b_in(cb_b_in), .cr_r_in(cr_r_in),
    .port_a(port_a), .port_b(port_b), .port_c(port_c)
  );

  task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic drive(input logic [IN_W-1:0] a, input logic [IN_W-1:0] b, input logic [IN_W-1:0] c);
    y_g_in  = a;
    cb_b_in = b;
    cr_r_in = c;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; oe_n = 1'b0; rgb_mode = 1'b0; convert = 1'b1;
    rnd10 = 1'b1; eq_dly_en = 1'b0;
    drive(14'sd400, 14'sd400, 14'sd400);
    tick(3);
    // R11: outputs zero during reset
    chk("R11 reset A", port_a, 10'd0);
    chk("R11 reset B", port_b, 10'd0);
    chk("R11 reset C", port_c, 10'd0);
    rst_n = 1'b1;
    tick(1);
    chk("R11 after release A", port_a, 10'd0);
    tick(6);

    // vector table
    for (int v = 0; v < 8; v++) begin
      rgb_mode = VEC[v].rgb;
      convert  = VEC[v].conv;
      rnd10    = VEC[v].r10;
      drive(VEC[v].a, VEC[v].b, VEC[v].c);
      tick(6);
      chk($sformatf("vec%0d A", v), port_a, VEC[v].ea);
      chk($sformatf("vec%0d B", v), port_b, VEC[v].eb);
      chk($sformatf("vec%0d C", v), port_c, VEC[v].ec);
    end

    // R8: luma stays unsigned with colour-difference modes set
    rgb_mode = 1'b0; convert = 1'b1; rnd10 = 1'b1;
    drive(14'sd2400, 14'sd0, 14'sd0);
    tick(6);
    chk("R8 luma unsigned above 511", port_a, 10'd600);
    chk("R5 zero diff twos", port_b, 10'd0);

    // R10: short path, 2 cycles
    eq_dly_en = 1'b0;
    drive(14'sd400, 14'sd400, 14'sd400);
    tick(6);
    drive(14'sd800, 14'sd800, 14'sd800);
    tick(1);
    chk("R10 short path edge1 holds", port_a, 10'd100);
    tick(1);
    chk("R10 short path edge2 new", port_a, 10'd200);

    // R10: long path, 4 cycles
    eq_dly_en = 1'b1;
    drive(14'sd400, 14'sd400, 14'sd400);
    tick(6);
    drive(14'sd1200, 14'sd1200, 14'sd1200);
    tick(3);
    chk("R10 long path edge3 holds", port_a, 10'd100);
    tick(1);
    chk("R10 long path edge4 new", port_a, 10'd300);
    eq_dly_en = 1'b0;

    // R9: output enable acts without a clock
    tick(4);
    #2 oe_n = 1'b1;
    #1;
    n_chk++;
    if (port_a === 10'd300 || port_b === 10'd300 || port_c === 10'd300) begin
      n_fail++;
      $display("FAIL R9 disabled ports actual=%0d expected=z", port_a);
    end
    oe_n = 1'b0;
    #1;
    chk("R9 re-enabled A", port_a, 10'd300);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule